// File: doc/BRIEF.md
# Dual Word Selector Unit

This block sits on the word side of a ternary associative array. It holds two selector vectors, P and S, each with one bit per array word. After a parallel search, the array delivers a per-word mismatch vector. The unit folds that vector into one selector. It can replace the selector with the vector, AND the vector into it, or OR the vector into it. The vector can be used as it is or inverted.

A selector can also be rotated by one word in either direction, with the end bit wrapping around. Rotation is the only path by which one word can pass information to its neighbour. As an alternative to rotation, a selector can be forced to all zeros or all ones.

Reads and writes of the array take their word-select vector from this unit. The source is P, S or a constant zero, and the source can be passed through or inverted. A zero flag for each selector gives the sequencer its branch condition.

Top module: `wsel_unit`

## Requirements
- R1: A synchronous active-high `rst` clears P and S to all zeros on the clock edge, so both zero flags read 1 afterwards.
- R2: With `ld_en`=1 and `ld_op`=0 (replace; code 3 also means replace), the selector picked by `ld_tgt` (0=P, 1=S) takes `mism` on the next edge, or `~mism` when `ld_inv`=1.
- R3: With `ld_op`=1, the picked selector becomes its old value ANDed with the conditioned mismatch vector.
- R4: With `ld_op`=2, the picked selector becomes its old value ORed with the conditioned mismatch vector.
- R5: With `sh_en`=1 and `sh_op`=0 (up), bit i of the picked selector (`sh_tgt`, 0=P, 1=S) takes old bit i+1, and the top bit takes old bit 0.
- R6: With `sh_op`=1 (down), bit i takes old bit i-1, and bit 0 takes the old top bit.
- R7: With `sh_op`=2, the picked selector is filled with zeros. With `sh_op`=3, it is filled with ones.
- R8: When a load and a shift both pick the same selector in one cycle, only the load takes effect. When they pick different selectors, both act.
- R9: `word_sel` is P when `rd_src`=0, S when `rd_src`=1, and zero when `rd_src`=2 or 3. The chosen value is bitwise inverted when `rd_inv`=1. The output is combinational from the current state.
- R10: `p_zero` and `s_zero` are 1 exactly when the matching selector holds all zeros.
- R11: A selector that is picked by neither an enabled load nor an enabled shift keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Apply the mismatch vector to a selector |
| ld_tgt | input | 1 | Load target: 0=P, 1=S |
| ld_op | input | 2 | 0 replace, 1 AND, 2 OR, 3 replace |
| ld_inv | input | 1 | Use the complemented mismatch vector |
| mism | input | NWORDS | Per-word mismatch from the search |
| sh_en | input | 1 | Shift or fill a selector |
| sh_tgt | input | 1 | Shift target: 0=P, 1=S |
| sh_op | input | 2 | 0 up, 1 down, 2 fill zeros, 3 fill ones |
| rd_src | input | 2 | Select source: 0 P, 1 S, 2/3 zero |
| rd_inv | input | 1 | Invert the select vector |
| word_sel | output | NWORDS | Word-select vector for array access |
| p_vec | output | NWORDS | Current P contents |
| s_vec | output | NWORDS | Current S contents |
| p_zero | output | 1 | P is all zeros |
| s_zero | output | 1 | S is all zeros |

## Verification
Loads, shifts, fills and reset change `p_vec`, `s_vec` and the zero flags exactly one clock edge after they are presented. `word_sel` follows `rd_src` and `rd_inv` in the same cycle, with no edge in between.

The bench drives every input just after a falling edge. It checks the selector state at the next falling edge against a model that was advanced once for the rising edge in between. It checks `word_sel` one time step after driving the read controls, using the model state for that same cycle.

// File: rtl/wsel_pkg.sv
package wsel_pkg;
  typedef enum logic [1:0] {
    CMB_REPL = 2'd0,
    CMB_AND  = 2'd1,
    CMB_OR   = 2'd2,
    CMB_REP2 = 2'd3
  } cmb_op_e;

  typedef enum logic [1:0] {
    SH_UP = 2'd0,
    SH_DN = 2'd1,
    SH_F0 = 2'd2,
    SH_F1 = 2'd3
  } sh_op_e;

  typedef enum logic [1:0] {
    SRC_P  = 2'd0,
    SRC_S  = 2'd1,
    SRC_Z0 = 2'd2,
    SRC_Z1 = 2'd3
  } src_e;

  localparam int NUM_SEL = 2;
endpackage

// File: rtl/wsel_slot.sv
module wsel_slot
  import wsel_pkg::*;
#(
  parameter int NWORDS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_hit,
  input  logic [1:0]        ld_op,
  input  logic [NWORDS-1:0] mvec,
  input  logic              sh_hit,
  input  logic [1:0]        sh_op,
  output logic [NWORDS-1:0] q
);
  logic [NWORDS-1:0] nxt;
  logic [NWORDS-1:0] rot_up;
  logic [NWORDS-1:0] rot_dn;

  generate
    if (NWORDS > 1) begin : g_rot
      assign rot_up = {q[0], q[NWORDS-1:1]};
      assign rot_dn = {q[NWORDS-2:0], q[NWORDS-1]};
    end else begin : g_one
      assign rot_up = q;
      assign rot_dn = q;
    end
  endgenerate

  always_comb begin
    nxt = q;
    if (ld_hit) begin
      case (ld_op)
        CMB_AND: nxt = q & mvec;
        CMB_OR:  nxt = q | mvec;
        default: nxt = mvec;
      endcase
    end else if (sh_hit) begin
      case (sh_op)
        SH_UP:   nxt = rot_up;
        SH_DN:   nxt = rot_dn;
        SH_F0:   nxt = '0;
        default: nxt = '1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/wsel_rdmux.sv
module wsel_rdmux
  import wsel_pkg::*;
#(
  parameter int NWORDS = 16
) (
  input  logic [NWORDS-1:0] p_in,
  input  logic [NWORDS-1:0] s_in,
  input  logic [1:0]        rd_src,
  input  logic              rd_inv,
  output logic [NWORDS-1:0] word_sel,
  output logic              p_zero,
  output logic              s_zero
);
  logic [NWORDS-1:0] raw;

  always_comb begin
    case (rd_src)
      SRC_P:   raw = p_in;
      SRC_S:   raw = s_in;
      default: raw = '0;
    endcase
    word_sel = rd_inv ? ~raw : raw;
  end

  assign p_zero = ~|p_in;
  assign s_zero = ~|s_in;
endmodule

// File: rtl/wsel_unit.sv
module wsel_unit
  import wsel_pkg::*;
#(
  parameter int NWORDS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic              ld_tgt,
  input  logic [1:0]        ld_op,
  input  logic              ld_inv,
  input  logic [NWORDS-1:0] mism,
  input  logic              sh_en,
  input  logic              sh_tgt,
  input  logic [1:0]        sh_op,
  input  logic [1:0]        rd_src,
  input  logic              rd_inv,
  output logic [NWORDS-1:0] word_sel,
  output logic [NWORDS-1:0] p_vec,
  output logic [NWORDS-1:0] s_vec,
  output logic              p_zero,
  output logic              s_zero
);
  logic [NWORDS-1:0] mvec;
  logic [NWORDS-1:0] sel_q [NUM_SEL];

  assign mvec = ld_inv ? ~mism : mism;

  generate
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
      wsel_slot #(.NWORDS(NWORDS)) slot_i (
        .clk    (clk),
        .rst    (rst),
        .ld_hit (ld_en && (ld_tgt == 1'(g))),
        .ld_op  (ld_op),
        .mvec   (mvec),
        .sh_hit (sh_en && (sh_tgt == 1'(g))),
        .sh_op  (sh_op),
        .q      (sel_q[g])
      );
    end
  endgenerate

  assign p_vec = sel_q[0];
  assign s_vec = sel_q[1];

  wsel_rdmux #(.NWORDS(NWORDS)) rdmux_i (
    .p_in     (sel_q[0]),
    .s_in     (sel_q[1]),
    .rd_src   (rd_src),
    .rd_inv   (rd_inv),
    .word_sel (word_sel),
    .p_zero   (p_zero),
    .s_zero   (s_zero)
  );
endmodule

// File: rtl/wsel_unit_chk.sv
module wsel_unit_chk #(
  parameter int NWORDS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_en,
  input logic              ld_tgt,
  input logic [1:0]        ld_op,
  input logic              ld_inv,
  input logic [NWORDS-1:0] mism,
  input logic              sh_en,
  input logic              sh_tgt,
  input logic [1:0]        sh_op,
  input logic [1:0]        rd_src,
  input logic              rd_inv,
  input logic [NWORDS-1:0] word_sel,
  input logic [NWORDS-1:0] p_vec,
  input logic [NWORDS-1:0] s_vec,
  input logic              p_zero,
  input logic              s_zero
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (p_vec == '0 && s_vec == '0 && p_zero && s_zero)); // R1
  AST_REPLACE_P: assert property (@(posedge clk) disable iff (rst)
    (ld_en && !ld_tgt && ld_op == 2'd0 && !ld_inv) |=> p_vec == $past(mism)); // R2
  AST_AND_NO_GROW: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_tgt && ld_op == 2'd1) |=> (s_vec & ~$past(s_vec)) == '0); // R3
  AST_OR_NO_SHRINK: assert property (@(posedge clk) disable iff (rst)
    (ld_en && !ld_tgt && ld_op == 2'd2) |=> (~p_vec & $past(p_vec)) == '0); // R4
  AST_ROT_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (sh_en && !sh_tgt && !sh_op[1] && !(ld_en && !ld_tgt))
      |=> $countones(p_vec) == $countones($past(p_vec))); // R5
  AST_FILL_ONES: assert property (@(posedge clk) disable iff (rst)
    (sh_en && sh_tgt && sh_op == 2'd3 && !(ld_en && ld_tgt)) |=> &s_vec); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (ld_en && sh_en && ld_tgt == sh_tgt && ld_tgt && ld_op == 2'd0 && ld_inv)
      |=> s_vec == ~$past(mism)); // R8
  AST_ZERO_SRC: assert property (@(posedge clk) disable iff (rst)
    rd_src[1] |-> (rd_inv ? (&word_sel) : (word_sel == '0))); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !sh_en) |=> ($stable(p_vec) && $stable(s_vec))); // R11
endmodule

bind wsel_unit wsel_unit_chk #(.NWORDS(NWORDS)) chk_i (.*);

// File: tb/wsel_unit_tb_top.sv
module wsel_unit_tb_top;
  localparam int N = 16;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst;
  logic         ld_en, ld_tgt, ld_inv, sh_en, sh_tgt, rd_inv;
  logic [1:0]   ld_op, sh_op, rd_src;
  logic [N-1:0] mism;
  logic [N-1:0] word_sel, p_vec, s_vec;
  logic         p_zero, s_zero;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] mp, ms;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsel_unit #(.NWORDS(N)) dut_i (.*);

  function automatic logic [N-1:0] f_next(input logic [N-1:0] old, input logic lh,
      input logic [1:0] lop, input logic [N-1:0] m, input logic sh, input logic [1:0] sop);
    logic [N-1:0] r;
    r = old;
    if (lh) begin
      if (lop == 2'd1)      r = old & m;
      else if (lop == 2'd2) r = old | m;
      else                  r = m;
    end else if (sh) begin
      for (int i = 0; i < N; i++) begin
        if (sop == 2'd0)      r[i] = old[(i + 1) % N];
        else if (sop == 2'd1) r[i] = old[(i + N - 1) % N];
        else if (sop == 2'd2) r[i] = 1'b0;
        else                  r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic string f_tag(input logic lh, input logic [1:0] lop, input logic sh,
      input logic [1:0] sop, input logic other_hit);
    if (lh && sh) return "R8";
    if (lh && other_hit) return "R8";
    if (lh) return (lop == 2'd1) ? "R3" : (lop == 2'd2) ? "R4" : "R2";
    if (sh && other_hit) return "R8";
    if (sh) return (sop == 2'd0) ? "R5" : (sop == 2'd1) ? "R6" : "R7";
    return "R11";
  endfunction

  function automatic logic [N-1:0] f_sel(input logic [N-1:0] p, input logic [N-1:0] s,
      input logic [1:0] src, input logic inv);
    logic [N-1:0] r;
    r = (src == 2'd0) ? p : (src == 2'd1) ? s : '0;
    return inv ? ~r : r;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tp, input string ts);
    chk(tp, p_vec, mp);
    chk(ts, s_vec, ms);
    chk("R10", {{(N-1){1'b0}}, p_zero}, {{(N-1){1'b0}}, (mp == '0)});
    chk("R10", {{(N-1){1'b0}}, s_zero}, {{(N-1){1'b0}}, (ms == '0)});
  endtask

  task automatic idle();
    ld_en = 0; ld_tgt = 0; ld_op = 0; ld_inv = 0; mism = '0;
    sh_en = 0; sh_tgt = 0; sh_op = 0; rd_src = 2'd2; rd_inv = 0;
  endtask

  // apply one cycle of stimulus (inputs already driven), advance model, check after edge
  task automatic step();
    logic lhp, lhs, shp, shs;
    logic [N-1:0] m;
    string tp, ts;
    #1;
    chk("R9", word_sel, f_sel(mp, ms, rd_src, rd_inv));
    m   = ld_inv ? ~mism : mism;
    lhp = ld_en && !ld_tgt; lhs = ld_en && ld_tgt;
    shp = sh_en && !sh_tgt; shs = sh_en && sh_tgt;
    tp = f_tag(lhp, ld_op, shp, sh_op, lhs || shs);
    ts = f_tag(lhs, ld_op, shs, sh_op, lhp || shp);
    mp = f_next(mp, lhp, ld_op, m, shp, sh_op);
    ms = f_next(ms, lhs, ld_op, m, shs, sh_op);
    @(negedge clk);
    check_state(tp, ts);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle();
    rst = 1;
    @(negedge clk); @(negedge clk);
    mp = '0; ms = '0;
    check_state("R1", "R1");
    rst = 0;

    // directed: replace P true, replace S complement
    @(negedge clk);
    ld_en = 1; ld_tgt = 0; ld_op = 0; mism = 16'h8421; step();
    ld_tgt = 1; ld_inv = 1; mism = 16'h00FF; step();
    // AND into S, OR into P
    ld_inv = 0; ld_op = 1; mism = 16'hF0F0; step();
    ld_tgt = 0; ld_op = 2; mism = 16'h0003; step();
    // rotate up / down with wrap across the ends
    idle(); ld_en = 1; ld_op = 0; mism = 16'h0001; step();
    idle(); sh_en = 1; sh_op = 0; step();
    sh_op = 1; step(); step();
    // fill ones on S, zeros on P
    sh_tgt = 1; sh_op = 3; step();
    sh_tgt = 0; sh_op = 2; step();
    // load beats shift on same target, both act on different targets
    ld_en = 1; ld_tgt = 1; ld_op = 0; mism = 16'h1234; sh_tgt = 1; sh_op = 2; step();
    sh_tgt = 0; sh_op = 3; step();
    // idle hold with every read source
    idle();
    for (int k = 0; k < 4; k++) begin
      rd_src = 2'(k); rd_inv = 1'(k & 1); step();
    end

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      ld_en  = ($urandom % 3) != 0;
      ld_tgt = 1'($urandom);
      ld_op  = 2'($urandom);
      ld_inv = 1'($urandom);
      mism   = ($urandom % 4 == 0) ? '0 : N'($urandom);
      sh_en  = ($urandom % 3) == 0;
      sh_tgt = 1'($urandom);
      sh_op  = 2'($urandom);
      rd_src = 2'($urandom);
      rd_inv = 1'($urandom);
      step();
    end

    // reset in mid-run
    idle(); rst = 1; mp = '0; ms = '0;
    @(negedge clk);
    check_state("R1", "R1");
    rst = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule